// File: doc/BRIEF.md
# Serial Flash Command Engine

This block lets a host CPU run one serial-flash transaction at a time through three 32-bit registers. Software first loads a command word, which holds the opcode byte and a 24-bit flash address, and a data word that holds up to four outgoing bytes. It then writes the control register with a transmit byte count, a receive byte count and the start bit. The engine lowers chip select and clocks out the selected bytes MSB-first in SPI mode 0. It then clocks in the response bytes and packs them into the data word. Busy stays high until chip select is released.

A single transmit count selects how much of one ordered byte stream goes out: the opcode only, opcode plus address, or opcode plus address plus one to four data bytes. A status poll uses one byte out and one byte in. A signature read sends the opcode and three address bytes, then receives one byte.

Top module: `spi_cmd_engine`

## Requirements
- R1: Registers sit at byte offsets 0x00 (control), 0x04 (command) and 0x08 (data); other offsets read zero. Control fields read back as written: transmit count [3:0], receive count [7:4], size [18:17], clock select [25:24]. Start (bit 8) always reads 0 and bit 16 reads busy. After reset all three registers read zero, chip select is high and the serial clock is low.
- R2: When idle, a control write with bit 8 set and a nonzero effective byte total starts a transaction, and bit 16 reads 1 from the next cycle until chip select rises. If both effective counts are zero, no transaction starts.
- R3: The outgoing stream is command[7:0], command[31:24], command[23:16], command[15:8], then data[7:0], data[15:8], data[23:16], data[31:24]. The first transmit-count bytes of this stream are sent, and a count above 8 acts as 8.
- R4: After the transmit bytes, receive-count bytes are clocked in with MOSI held low, and a count above 4 acts as 4. Received byte k lands in data[8k+7:8k] and the unfilled upper bytes read zero. With a receive count of 0 the data register keeps its written value.
- R5: SPI mode 0, MSB first: the clock idles low and MOSI is sampled on the rising edge. Chip select falls once and rises once per transaction and stays low across all bytes.
- R6: The serial clock period is 2, 4, 8 or 16 system clocks for clock select 0, 1, 2 and 3, and it is uniform across byte boundaries.
- R7: While busy, writes to any register are ignored, including a new start.
- R8: The size field has no effect on the bytes sent, the bytes received or the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Two things can land on the same clock edge. One is the completion of the final byte, where busy drops and the data register takes the received bytes. The other is host register traffic, which is ignored while busy but accepted one cycle later. The bench writes the command and data registers during a transfer and attempts a second start. It then judges the outcome at the ports: the byte count seen by a model flash, the register readback, and the polling of busy until it falls. A sweep of every transmit count, receive count and clock select, with counts beyond the limits, checks the byte stream, the packing of the received bytes and the clock period against values computed in the bench.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 4;
    localparam int SEL_W  = 2;
    localparam int MAX_TX = 8;
    localparam int MAX_RX = 4;

    localparam logic [1:0] SLOT_CTRL = 2'd0;
    localparam logic [1:0] SLOT_CMD  = 2'd1;
    localparam logic [1:0] SLOT_DATA = 2'd2;

    localparam int GO_BIT   = 8;
    localparam int BUSY_BIT = 16;

    typedef struct packed {
        logic [SEL_W-1:0] clk_sel;
        logic [1:0]       size;
        logic [CNT_W-1:0] rx_cnt;
        logic [CNT_W-1:0] tx_cnt;
    } ctrl_t;

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;

    function automatic ctrl_t ctrl_from_word(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.tx_cnt  = w[3:0];
        c.rx_cnt  = w[7:4];
        c.size    = w[18:17];
        c.clk_sel = w[25:24];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_to_word(input ctrl_t c, input logic busy);
        logic [WORD_W-1:0] w;
        w          = '0;
        w[3:0]     = c.tx_cnt;
        w[7:4]     = c.rx_cnt;
        w[BUSY_BIT] = busy;
        w[18:17]   = c.size;
        w[25:24]   = c.clk_sel;
        return w;
    endfunction

    function automatic logic [CNT_W-1:0] clamp_tx(input logic [CNT_W-1:0] n);
        return (n > CNT_W'(MAX_TX)) ? CNT_W'(MAX_TX) : n;
    endfunction

    function automatic logic [CNT_W-1:0] clamp_rx(input logic [CNT_W-1:0] n);
        return (n > CNT_W'(MAX_RX)) ? CNT_W'(MAX_RX) : n;
    endfunction

    // Byte idx of the unified outgoing stream: opcode, address high..low, data low..high
    function automatic logic [7:0] stream_byte(input logic [WORD_W-1:0] cmd,
                                               input logic [WORD_W-1:0] dat,
                                               input logic [CNT_W-1:0] idx);
        case (idx)
            4'd0:    return cmd[7:0];
            4'd1:    return cmd[31:24];
            4'd2:    return cmd[23:16];
            4'd3:    return cmd[15:8];
            4'd4:    return dat[7:0];
            4'd5:    return dat[15:8];
            4'd6:    return dat[23:16];
            4'd7:    return dat[31:24];
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'((1 << sel) - 1);
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt_q <= '0;
        else                     cnt_q <= cnt_q + CNT_W'(1);
    end

    // R6
    div_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && sel != '0) |=> !tick);

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       tick,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    logic [7:0] tx_q, rx_q;
    logic [2:0] bit_q;
    logic       sclk_q, act_q;

    assign done    = act_q && tick && sclk_q && (bit_q == 3'd7);
    assign sclk    = sclk_q;
    assign mosi    = act_q & tx_q[7];
    assign rx_byte = rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q   <= '0;
            rx_q   <= '0;
            bit_q  <= '0;
            sclk_q <= 1'b0;
            act_q  <= 1'b0;
        end else if (load) begin
            tx_q   <= load_byte;
            bit_q  <= '0;
            sclk_q <= 1'b0;
            act_q  <= 1'b1;
        end else if (done) begin
            act_q  <= 1'b0;
            sclk_q <= 1'b0;
        end else if (act_q && tick) begin
            if (!sclk_q) begin
                sclk_q <= 1'b1;
                rx_q   <= {rx_q[6:0], miso};
            end else begin
                sclk_q <= 1'b0;
                tx_q   <= {tx_q[6:0], 1'b0};
                bit_q  <= bit_q + 3'd1;
            end
        end
    end

    // R5
    sclk_low_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !sclk_q);

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_cs_n,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    ctrl_t              ctrl_q;
    logic [WORD_W-1:0]  cmd_q, data_q, rxbuf_q, rx_merge;
    seq_state_e         st_q;
    logic [CNT_W-1:0]   idx_q, load_idx, cur_tx, cur_rx, cur_total, rdiff;
    logic               busy, slot_ok, wr_ok, start_go, more, last, load, tick, sh_done;
    logic [1:0]         slot;
    ctrl_t              wr_ctrl;
    logic [7:0]         load_byte, sh_rx;

    assign busy    = (st_q == SEQ_RUN);
    assign slot    = reg_addr[3:2];
    assign slot_ok = (reg_addr[1:0] == 2'b00);
    assign wr_ok   = reg_wr && slot_ok && !busy;
    assign wr_ctrl = ctrl_from_word(reg_wdata);

    assign start_go = wr_ok && (slot == SLOT_CTRL) && reg_wdata[GO_BIT] &&
                      ((clamp_tx(wr_ctrl.tx_cnt) + clamp_rx(wr_ctrl.rx_cnt)) != '0);

    assign cur_tx    = start_go ? clamp_tx(wr_ctrl.tx_cnt) : clamp_tx(ctrl_q.tx_cnt);
    assign cur_rx    = start_go ? clamp_rx(wr_ctrl.rx_cnt) : clamp_rx(ctrl_q.rx_cnt);
    assign cur_total = cur_tx + cur_rx;

    assign more     = busy && sh_done && ((idx_q + 4'd1) < cur_total);
    assign last     = busy && sh_done && !((idx_q + 4'd1) < cur_total);
    assign load     = start_go || more;
    assign load_idx = start_go ? '0 : (idx_q + 4'd1);
    assign load_byte = (load_idx < cur_tx) ? stream_byte(cmd_q, data_q, load_idx) : 8'h00;

    // receive byte placement: position = current index minus transmit count
    assign rdiff    = idx_q - cur_tx;
    assign rx_merge = (busy && sh_done && (idx_q >= cur_tx)) ?
                      (rxbuf_q | ({24'b0, sh_rx} << {rdiff, 3'b000})) : rxbuf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            cmd_q   <= '0;
            data_q  <= '0;
            rxbuf_q <= '0;
            idx_q   <= '0;
            st_q    <= SEQ_IDLE;
        end else begin
            if (wr_ok) begin
                case (slot)
                    SLOT_CTRL: ctrl_q <= wr_ctrl;
                    SLOT_CMD:  cmd_q  <= reg_wdata;
                    SLOT_DATA: data_q <= reg_wdata;
                    default: ;
                endcase
            end
            if (start_go) begin
                st_q    <= SEQ_RUN;
                idx_q   <= '0;
                rxbuf_q <= '0;
            end else if (more) begin
                idx_q   <= idx_q + 4'd1;
                rxbuf_q <= rx_merge;
            end else if (last) begin
                st_q <= SEQ_IDLE;
                if (cur_rx != '0) data_q <= rx_merge;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (slot_ok) begin
            case (slot)
                SLOT_CTRL: reg_rdata = ctrl_to_word(ctrl_q, busy);
                SLOT_CMD:  reg_rdata = cmd_q;
                SLOT_DATA: reg_rdata = data_q;
                default:   reg_rdata = '0;
            endcase
        end
    end

    assign spi_cs_n = !busy;

    spi_clk_div #(.SEL_W(SEL_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .sel  (ctrl_q.clk_sel),
        .tick (tick)
    );

    spi_byte_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_byte (load_byte),
        .tick      (tick),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .done      (sh_done),
        .rx_byte   (sh_rx)
    );

    // R2
    start_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(reg_wr && reg_addr == 4'h0 && reg_wdata[GO_BIT]));

    // R7
    busy_write_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wr) |=> ($stable(cmd_q) && $stable(ctrl_q)));

    // R5
    cs_idle_clk_chk: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    // R3
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx_q < cur_total));

endmodule

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    wire  [31:0] reg_rdata;
    wire         spi_cs_n, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;

    always #5 clk = ~clk;

    spi_cmd_engine u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- model flash ----------------
    logic [7:0] seed = 8'h00;
    logic [7:0] mosi_log [0:15];
    int  n_bytes = 0, bitpos = 0, cs_falls = 0, cs_rises = 0;
    logic [7:0] cur = 0;
    longint last_rise = 0, min_per = 0, max_per = 0;
    bit have_rise = 0;

    function automatic logic [7:0] sbyte(input int j);
        return (seed + 8'(j) * 8'h3B) ^ 8'hA5;
    endfunction

    function automatic logic miso_bit(input int b);
        logic [7:0] v;
        v = sbyte(b / 8);
        return v[7 - (b % 8)];
    endfunction

    always @(negedge spi_cs_n) begin
        cs_falls++;
        bitpos = 0; n_bytes = 0; cur = 0; have_rise = 0;
        min_per = 64'd1000000; max_per = 0;
        spi_miso = miso_bit(0);
    end

    always @(posedge spi_cs_n) cs_rises++;

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            cur = {cur[6:0], spi_mosi};
            if (bitpos % 8 == 7) begin
                if (n_bytes < 16) mosi_log[n_bytes] = cur;
                n_bytes++;
            end
            if (have_rise) begin
                if ($time - last_rise < min_per) min_per = $time - last_rise;
                if ($time - last_rise > max_per) max_per = $time - last_rise;
            end
            have_rise = 1;
            last_rise = $time;
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n) begin
            bitpos++;
            spi_miso = miso_bit(bitpos);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int guard;
        guard = 0;
        rd(4'h0, v);
        while (v[16] && guard < 5000) begin
            rd(4'h0, v);
            guard++;
        end
        check(req, "busy clears", {31'b0, v[16]}, 32'd0);
    endtask

    function automatic logic [31:0] ctrl_word(input int tx, input int rx, input int sel,
                                              input int size, input bit go);
        logic [31:0] w;
        w = '0;
        w[3:0] = 4'(tx); w[7:4] = 4'(rx); w[8] = go;
        w[18:17] = 2'(size); w[25:24] = 2'(sel);
        return w;
    endfunction

    function automatic logic [7:0] exp_tx(input logic [31:0] cmd, input logic [31:0] dat, input int i);
        if (i == 0) return cmd[7:0];
        if (i < 4)  return cmd[31 - 8*(i-1) -: 8];
        return dat[8*(i-4) +: 8];
    endfunction

    task automatic run_txn(input logic [31:0] cmd, input logic [31:0] dat, input int tx,
                           input int rx, input int sel, input int size);
        logic [31:0] v, expd;
        int etx, erx, tot;
        etx = (tx > 8) ? 8 : tx;
        erx = (rx > 4) ? 4 : rx;
        tot = etx + erx;
        seed = seed + 8'h17;
        wr(4'h4, cmd);
        wr(4'h8, dat);
        cs_falls = 0; cs_rises = 0;
        wr(4'h0, ctrl_word(tx, rx, sel, size, 1'b1));
        rd(4'h0, v);
        // R2: busy right after start, or no start when both counts are zero
        check("R2", "busy after start", {31'b0, v[16]}, (tot != 0) ? 32'd1 : 32'd0);
        wait_idle("R2");
        // R1 readback of control fields, start bit reads 0
        rd(4'h0, v);
        check("R1", "ctrl readback", v, ctrl_word(tx, rx, sel, size, 1'b0));
        if (tot == 0) begin
            check("R2", "no cs activity", 32'(cs_falls), 32'd0);
        end else begin
            // R5 single chip-select window
            check("R5", "cs falls/rises", 32'(cs_falls * 16 + cs_rises), 32'd17);
            check("R3", "byte total", 32'(n_bytes), 32'(tot));
            for (int i = 0; i < etx; i++)
                check("R3", "tx byte", {24'b0, mosi_log[i]}, {24'b0, exp_tx(cmd, dat, i)});
            for (int i = etx; i < tot; i++)
                check("R4", "mosi low in rx", {24'b0, mosi_log[i]}, 32'd0);
            // R6 (and R8: size varies across the sweep without altering timing)
            check("R6", "min sclk period", 32'(min_per), 32'((2 << sel) * 10));
            check("R6", "max sclk period", 32'(max_per), 32'((2 << sel) * 10));
        end
        expd = dat;
        if (erx > 0 && tot > 0) begin
            expd = '0;
            for (int k = 0; k < erx; k++) expd[8*k +: 8] = sbyte(etx + k);
        end
        rd(4'h8, v);
        check("R4", "data register", v, expd);
        rd(4'h4, v);
        check("R8", "cmd register kept", v, cmd);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cs_falls = 0; cs_rises = 0;

        // R1 reset state
        rd(4'h0, v); check("R1", "ctrl reset", v, 32'd0);
        rd(4'h4, v); check("R1", "cmd reset", v, 32'd0);
        rd(4'h8, v); check("R1", "data reset", v, 32'd0);
        check("R1", "cs_n reset", {31'b0, spi_cs_n}, 32'd1);
        check("R1", "sclk reset", {31'b0, spi_sclk}, 32'd0);
        rd(4'hC, v); check("R1", "unmapped offset", v, 32'd0);

        // status poll and signature read shapes
        run_txn(32'h0000_0005, 32'hFFFF_FFFF, 1, 1, 0, 0);
        run_txn(32'h0000_00AB, 32'h1234_5678, 4, 1, 1, 3);

        // R3/R4 sweep over all counts and clock selects
        n = 0;
        for (int sel = 0; sel < 4; sel++)
            for (int tx = 0; tx <= 8; tx++)
                for (int rx = 0; rx <= 4; rx++) begin
                    run_txn(32'h9E37_79B9 * 32'(n + 1), 32'hC2B2_AE35 ^ (32'(n) * 32'h0100_0193),
                            tx, rx, sel, n % 4);
                    n++;
                end

        // R3 and R4 clamping of oversize counts
        run_txn(32'hA1B2_C3D4, 32'h5566_7788, 12, 9, 0, 1);
        run_txn(32'h0F1E_2D3C, 32'h4B5A_6978, 15, 15, 1, 2);
        run_txn(32'h0000_0000, 32'hDEAD_BEEF, 0, 7, 0, 0);

        // R7 writes while busy are ignored
        wr(4'h4, 32'h1122_3344);
        wr(4'h8, 32'h5566_7788);
        cs_falls = 0;
        wr(4'h0, ctrl_word(8, 0, 3, 0, 1'b1));
        wr(4'h4, 32'hFFFF_FFFF);
        wr(4'h8, 32'h0000_0000);
        wr(4'h0, ctrl_word(1, 2, 0, 3, 1'b1));
        wait_idle("R7");
        check("R7", "bytes of first txn only", 32'(n_bytes), 32'd8);
        check("R7", "single cs window", 32'(cs_falls), 32'd1);
        rd(4'h4, v); check("R7", "cmd unchanged", v, 32'h1122_3344);
        rd(4'h8, v); check("R7", "data unchanged", v, 32'h5566_7788);
        rd(4'h0, v); check("R7", "ctrl unchanged", v, ctrl_word(8, 0, 3, 0, 1'b0));

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule